// File: doc/BRIEF.md
# Lockable Raster Sync Generator

This block produces active-low horizontal, vertical and composite sync for a standard-definition digital video raster clocked at 27 MHz. Two counters track the raster position: a pixel-clock counter that wraps at the line length and a line counter that advances on each line wrap and wraps at the frame length. Sync pulse edges are placed by programmable counter values. The generator needs no outside timing and free-runs in master mode after its own reset.

An external vertical reference can be fed in. When that input shows an edge of the programmed polarity, the generator goes into slave mode and stays there. On that edge it stores where its counters stood and reloads them with a programmed raster position. A host compares the stored position with the intended one to steer the pixel clock. That steering loop is outside this block.

The chip-wide power-on reset does not disturb the raster. Only the generator's own reset reinitialises it.

Top module: `raster_sync_gen`

## Requirements
- R1: Bit 0 of configuration register 0 selects the triggering edge of `ext_vsync`: 1 selects a rising edge and 0 a falling edge. An edge of the other direction has no effect on the counters, the captures, `cap_valid` or the mode.
- R2: Without a triggering edge the counters free-run. `h_pos` counts 0 to LINE_CLKS-1 and then returns to 0. `v_pos` advances by one whenever `h_pos` wraps and returns to 0 after FRAME_LINES-1. `slave_mode` stays 0.
- R3: `ext_vsync` passes through a two-flop synchroniser. On the third rising clock edge after it changes, a triggering edge loads `h_pos` with register 1 (horizontal offset) and `v_pos` with register 2 (vertical offset). Counting then resumes from the loaded position, with wrap if the offset is the last value.
- R4: On the same clock edge, `cap_hpos` and `cap_vpos` take the counter values from just before the reload. They hold those values until the next triggering edge.
- R5: `cap_valid` is high for exactly the one cycle that follows the load.
- R6: The first triggering edge sets `slave_mode` to 1. It stays 1 until `gen_rst_n` is asserted.
- R7: `hs_n` is low in a cycle when, one cycle earlier, `h_pos` was inside the window [register 3, register 4). If register 3 is greater than register 4 the window wraps past the end of the line. If the two are equal the window is empty.
- R8: `vs_n` follows the same rule as R7 for `v_pos`, using the window [register 5, register 6).
- R9: `cs_n` is low whenever the vertical window of R8 is active. Outside it, `cs_n` follows the horizontal window of R7 with the same one-cycle lag.
- R10: While `por_n` is low, only `cap_valid` is forced to 0. The counters, the captures, `slave_mode`, all configuration registers and the sync outputs carry on as if `por_n` were high.
- R11: While `gen_rst_n` is low, the counters and captures are 0, `slave_mode` is 0, all sync outputs are 1, the polarity bit is 1 and the other configuration registers are 0. A write to register 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz pixel clock |
| gen_rst_n | input | 1 | Generator reset, active low |
| por_n | input | 1 | Chip power-on reset, active low; clears only `cap_valid` |
| ext_vsync | input | 1 | External vertical reference, asynchronous |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | CW | Configuration write data |
| hs_n | output | 1 | Horizontal sync, active low |
| vs_n | output | 1 | Vertical sync, active low |
| cs_n | output | 1 | Composite sync, active low |
| h_pos | output | HW | Pixel position within the line |
| v_pos | output | VW | Line position within the frame |
| slave_mode | output | 1 | 1 once locked to the external reference |
| cap_hpos | output | HW | Pixel position captured at the last triggering edge |
| cap_vpos | output | VW | Line position captured at the last triggering edge |
| cap_valid | output | 1 | One-cycle strobe marking a fresh capture |

## Verification
The bench drives reference edges of both directions under both polarity settings. A design that ignored the polarity bit would reload on the wrong edge, and that shows up as a broken count sequence and a stray `cap_valid`.

The capture is compared with the position sampled one cycle before the reload. A design that stored the position after the reload would report the offset instead of the phase. The counters are also loaded with the last pixel position, so a wrap off a loaded value that skips or repeats a step is caught.

Sync windows are checked over whole frames, both as plain windows and as windows that wrap past the end of the line or frame. An off-by-one compare or missing wrap handling shows up there as a shifted or missing pulse. Finally, `por_n` is pulsed in the middle of a run. A design that tied it into the raster would lose count continuity, drop slave mode or forget its offsets.

// File: rtl/raster_sync_pkg.sv
package raster_sync_pkg;

  // configuration register selects
  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_HOFF   = 3'd1,
    REG_VOFF   = 3'd2,
    REG_HFALL  = 3'd3,
    REG_HRISE  = 3'd4,
    REG_VFALL  = 3'd5,
    REG_VRISE  = 3'd6
  } cfg_sel_e;

  typedef enum logic {
    MODE_MASTER = 1'b0,
    MODE_SLAVE  = 1'b1
  } sync_mode_e;

endpackage

// File: rtl/raster_sync_cfg.sv
module raster_sync_cfg
  import raster_sync_pkg::*;
#(
  parameter int HW = 11,
  parameter int VW = 10,
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic          pol_rise,
  output logic [HW-1:0] h_off,
  output logic [VW-1:0] v_off,
  output logic [HW-1:0] h_fall,
  output logic [HW-1:0] h_rise,
  output logic [VW-1:0] v_fall,
  output logic [VW-1:0] v_rise
);

  logic          pol_d;
  logic [HW-1:0] h_off_d, h_fall_d, h_rise_d;
  logic [VW-1:0] v_off_d, v_fall_d, v_rise_d;

  always_comb begin
    pol_d    = pol_rise;
    h_off_d  = h_off;
    v_off_d  = v_off;
    h_fall_d = h_fall;
    h_rise_d = h_rise;
    v_fall_d = v_fall;
    v_rise_d = v_rise;
    if (we) begin
      unique case (cfg_sel_e'(addr))
        REG_CTRL:  pol_d    = wdata[0];
        REG_HOFF:  h_off_d  = wdata[HW-1:0];
        REG_VOFF:  v_off_d  = wdata[VW-1:0];
        REG_HFALL: h_fall_d = wdata[HW-1:0];
        REG_HRISE: h_rise_d = wdata[HW-1:0];
        REG_VFALL: v_fall_d = wdata[VW-1:0];
        REG_VRISE: v_rise_d = wdata[VW-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_rise <= 1'b1;
      h_off    <= '0;
      v_off    <= '0;
      h_fall   <= '0;
      h_rise   <= '0;
      v_fall   <= '0;
      v_rise   <= '0;
    end else begin
      pol_rise <= pol_d;
      h_off    <= h_off_d;
      v_off    <= v_off_d;
      h_fall   <= h_fall_d;
      h_rise   <= h_rise_d;
      v_fall   <= v_fall_d;
      v_rise   <= v_rise_d;
    end
  end

  // R11: a write to an unused select leaves every register as it was
  a_r11_unused_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 3'd7) |=> ($stable(h_off) && $stable(v_off) && $stable(pol_rise)));

endmodule

// File: rtl/raster_sync_edge.sv
module raster_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  input  logic pol_rise,
  output logic trig
);

  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= ext_in;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  always_comb begin
    if (pol_rise) trig = sync_q & ~last_q;
    else          trig = ~sync_q & last_q;
  end

  // R3: a detected edge is a single-cycle event
  a_r3_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

endmodule

// File: rtl/raster_sync_counter.sv
module raster_sync_counter #(
  parameter int LINE_CLKS   = 1716,
  parameter int FRAME_LINES = 525,
  parameter int HW          = 11,
  parameter int VW          = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [HW-1:0] h_ld,
  input  logic [VW-1:0] v_ld,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt
);

  localparam logic [HW-1:0] H_LAST = HW'(LINE_CLKS - 1);
  localparam logic [VW-1:0] V_LAST = VW'(FRAME_LINES - 1);

  logic [HW-1:0] h_d;
  logic [VW-1:0] v_d;
  logic          line_end;

  assign line_end = (h_cnt == H_LAST);

  always_comb begin
    h_d = h_cnt;
    v_d = v_cnt;
    if (load) begin
      h_d = h_ld;
      v_d = v_ld;
    end else if (line_end) begin
      h_d = '0;
      v_d = (v_cnt == V_LAST) ? '0 : v_cnt + 1'b1;
    end else begin
      h_d = h_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else begin
      h_cnt <= h_d;
      v_cnt <= v_d;
    end
  end

  // R2: pixel counter stays within the line
  a_r2_h_range: assert property (@(posedge clk) disable iff (!rst_n)
    h_cnt <= H_LAST);
  // R2: the pixel counter returns to zero after the last pixel
  a_r2_h_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && line_end) |=> (h_cnt == '0));
  // R3: a load places the raster at the requested position
  a_r3_load_pos: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (h_cnt == $past(h_ld) && v_cnt == $past(v_ld)));

endmodule

// File: rtl/raster_sync_window.sv
module raster_sync_window #(
  parameter int W = 11
) (
  input  logic [W-1:0] pos,
  input  logic [W-1:0] start,
  input  logic [W-1:0] stop,
  output logic         active
);

  logic after_start, before_stop;

  assign after_start = (pos >= start);
  assign before_stop = (pos <  stop);

  always_comb begin
    if (start <= stop) active = after_start & before_stop;
    else               active = after_start | before_stop;
  end

endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
  import raster_sync_pkg::*;
#(
  parameter  int LINE_CLKS   = 1716,
  parameter  int FRAME_LINES = 525,
  localparam int HW          = $clog2(LINE_CLKS),
  localparam int VW          = $clog2(FRAME_LINES),
  localparam int CW          = (HW > VW) ? HW : VW
) (
  input  logic          clk,
  input  logic          gen_rst_n,
  input  logic          por_n,
  input  logic          ext_vsync,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  output logic          hs_n,
  output logic          vs_n,
  output logic          cs_n,
  output logic [HW-1:0] h_pos,
  output logic [VW-1:0] v_pos,
  output logic          slave_mode,
  output logic [HW-1:0] cap_hpos,
  output logic [VW-1:0] cap_vpos,
  output logic          cap_valid
);

  logic          pol_rise, trig;
  logic [HW-1:0] h_off, h_fall, h_rise;
  logic [VW-1:0] v_off, v_fall, v_rise;
  logic          h_act, v_act;
  sync_mode_e    mode_q, mode_d;
  logic          valid_rst_n;

  raster_sync_cfg #(.HW(HW), .VW(VW), .CW(CW)) u_cfg (
    .clk(clk), .rst_n(gen_rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .pol_rise(pol_rise), .h_off(h_off), .v_off(v_off),
    .h_fall(h_fall), .h_rise(h_rise), .v_fall(v_fall), .v_rise(v_rise)
  );

  raster_sync_edge u_edge (
    .clk(clk), .rst_n(gen_rst_n), .ext_in(ext_vsync), .pol_rise(pol_rise), .trig(trig)
  );

  raster_sync_counter #(.LINE_CLKS(LINE_CLKS), .FRAME_LINES(FRAME_LINES), .HW(HW), .VW(VW)) u_cnt (
    .clk(clk), .rst_n(gen_rst_n), .load(trig), .h_ld(h_off), .v_ld(v_off),
    .h_cnt(h_pos), .v_cnt(v_pos)
  );

  raster_sync_window #(.W(HW)) u_hwin (
    .pos(h_pos), .start(h_fall), .stop(h_rise), .active(h_act)
  );

  raster_sync_window #(.W(VW)) u_vwin (
    .pos(v_pos), .start(v_fall), .stop(v_rise), .active(v_act)
  );

  // sync outputs, registered for glitch-free pins
  always_ff @(posedge clk or negedge gen_rst_n) begin
    if (!gen_rst_n) begin
      hs_n <= 1'b1;
      vs_n <= 1'b1;
      cs_n <= 1'b1;
    end else begin
      hs_n <= ~h_act;
      vs_n <= ~v_act;
      cs_n <= ~(h_act | v_act);
    end
  end

  // capture of the pre-reload position
  always_ff @(posedge clk or negedge gen_rst_n) begin
    if (!gen_rst_n) begin
      cap_hpos <= '0;
      cap_vpos <= '0;
    end else if (trig) begin
      cap_hpos <= h_pos;
      cap_vpos <= v_pos;
    end
  end

  always_comb begin
    mode_d = mode_q;
    if (trig) mode_d = MODE_SLAVE;
  end

  always_ff @(posedge clk or negedge gen_rst_n) begin
    if (!gen_rst_n) mode_q <= MODE_MASTER;
    else            mode_q <= mode_d;
  end

  assign slave_mode = (mode_q == MODE_SLAVE);

  // only the capture strobe listens to the power-on reset
  assign valid_rst_n = gen_rst_n & por_n;

  always_ff @(posedge clk or negedge valid_rst_n) begin
    if (!valid_rst_n) cap_valid <= 1'b0;
    else              cap_valid <= trig;
  end

  // R4: capture holds the counter position seen at the reload edge
  a_r4_capture: assert property (@(posedge clk) disable iff (!gen_rst_n)
    trig |=> (cap_hpos == $past(h_pos) && cap_vpos == $past(v_pos)));
  // R5: capture strobe lasts one cycle
  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!gen_rst_n)
    cap_valid |=> !cap_valid);
  // R6: slave mode is sticky
  a_r6_mode_sticky: assert property (@(posedge clk) disable iff (!gen_rst_n)
    slave_mode |=> slave_mode);
  // R9: the vertical interval forces composite sync low
  a_r9_cs_vertical: assert property (@(posedge clk) disable iff (!gen_rst_n)
    !vs_n |-> !cs_n);
  // R10: power-on reset leaves the raster counters running
  a_r10_por_raster: assert property (@(posedge clk) disable iff (!gen_rst_n)
    (!por_n && !trig && h_pos != HW'(LINE_CLKS - 1)) |=> (h_pos == $past(h_pos) + 1'b1));

endmodule

// File: tb/raster_sync_gen_tb_top.sv
module raster_sync_gen_tb_top;

  localparam int LINE  = 64;
  localparam int FRAME = 16;
  localparam int HW    = 6;
  localparam int VW    = 4;
  localparam int CW    = 6;

  logic          clk;
  logic          gen_rst_n, por_n, ext_vsync, cfg_we;
  logic [2:0]    cfg_addr;
  logic [CW-1:0] cfg_wdata;
  logic          hs_n, vs_n, cs_n, slave_mode, cap_valid;
  logic [HW-1:0] h_pos, cap_hpos;
  logic [VW-1:0] v_pos, cap_vpos;

  int n_chk  = 0;
  int n_fail = 0;
  int m_hoff = 0, m_voff = 0, m_hf = 0, m_hr = 0, m_vf = 0, m_vr = 0;
  bit done = 0;

  raster_sync_gen #(.LINE_CLKS(LINE), .FRAME_LINES(FRAME)) dut_i (
    .clk(clk), .gen_rst_n(gen_rst_n), .por_n(por_n), .ext_vsync(ext_vsync),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .hs_n(hs_n), .vs_n(vs_n), .cs_n(cs_n), .h_pos(h_pos), .v_pos(v_pos),
    .slave_mode(slave_mode), .cap_hpos(cap_hpos), .cap_vpos(cap_vpos), .cap_valid(cap_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit win(input int p, input int f, input int r);
    if (f <= r) return (p >= f) && (p < r);
    return (p >= f) || (p < r);
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = CW'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      1: m_hoff = d; 2: m_voff = d; 3: m_hf = d; 4: m_hr = d; 5: m_vf = d; 6: m_vr = d;
      default: ;
    endcase
  endtask

  // R11
  task automatic t_reset();
    gen_rst_n = 1'b0; por_n = 1'b1; ext_vsync = 1'b0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    chk(h_pos == 0 && v_pos == 0, "R11", "counters in reset", int'(h_pos) + int'(v_pos), 0);
    chk(!slave_mode && !cap_valid, "R11", "mode/valid in reset", int'(slave_mode) + int'(cap_valid), 0);
    chk(hs_n && vs_n && cs_n, "R11", "sync pins in reset", int'({hs_n, vs_n, cs_n}), 7);
    chk(cap_hpos == 0 && cap_vpos == 0, "R11", "captures in reset", int'(cap_hpos) + int'(cap_vpos), 0);
    gen_rst_n = 1'b1;
  endtask

  // R2, R7 (empty windows after reset), R11 (unused select)
  task automatic t_free_run();
    int ph, pv, eh, ev, bad_a, bad_e, bad_c, sync_low;
    bit wrapped;
    bad_c = 0; sync_low = 0; wrapped = 0; bad_a = 0; bad_e = 0;
    wr(7, 5);
    @(negedge clk); ph = h_pos; pv = v_pos;
    for (int i = 0; i < LINE * FRAME + 20; i++) begin
      @(negedge clk);
      eh = (ph == LINE - 1) ? 0 : ph + 1;
      ev = (ph == LINE - 1) ? ((pv == FRAME - 1) ? 0 : pv + 1) : pv;
      if (ph == LINE - 1 && pv == FRAME - 1) wrapped = 1;
      if ((h_pos != eh || v_pos != ev) && bad_c == 0) begin bad_a = h_pos * 100 + v_pos; bad_e = eh * 100 + ev; end
      if (h_pos != eh || v_pos != ev) bad_c++;
      if (!hs_n || !vs_n || !cs_n) sync_low++;
      ph = h_pos; pv = v_pos;
    end
    chk(bad_c == 0, "R2", "count sequence h*100+v", bad_a, bad_e);
    chk(wrapped, "R2", "frame wrap seen", int'(wrapped), 1);
    chk(!slave_mode, "R2", "stays master", int'(slave_mode), 0);
    chk(sync_low == 0, "R7", "empty windows keep sync high", sync_low, 0);
    chk(m_hoff == 0 && !cap_valid, "R11", "unused select write", int'(cap_valid), 0);
  endtask

  // R7, R8, R9
  task automatic t_windows(input int hf, input int hr, input int vf, input int vr, input string tag);
    int ph, pv, bh, bv, bc;
    bh = 0; bv = 0; bc = 0;
    wr(3, hf); wr(4, hr); wr(5, vf); wr(6, vr);
    ph = h_pos; pv = v_pos;
    for (int i = 0; i < LINE * FRAME + 10; i++) begin
      @(negedge clk);
      if (hs_n != !win(ph, m_hf, m_hr)) bh++;
      if (vs_n != !win(pv, m_vf, m_vr)) bv++;
      if (cs_n != !(win(ph, m_hf, m_hr) || win(pv, m_vf, m_vr))) bc++;
      ph = h_pos; pv = v_pos;
    end
    chk(bh == 0, "R7", {"hs window ", tag}, bh, 0);
    chk(bv == 0, "R8", {"vs window ", tag}, bv, 0);
    chk(bc == 0, "R9", {"cs composite ", tag}, bc, 0);
  endtask

  // R1, R3, R4, R5, R6
  task automatic t_edge(input logic lvl, input bit fire, input string tag);
    int hb, vb, mb, cb;
    @(negedge clk) ext_vsync = lvl;
    @(posedge clk); @(posedge clk);
    @(negedge clk); hb = h_pos; vb = v_pos; mb = slave_mode; cb = cap_hpos;
    @(posedge clk);
    @(negedge clk);
    if (fire) begin
      chk(h_pos == m_hoff && v_pos == m_voff, "R3", {"reload ", tag}, h_pos * 100 + v_pos, m_hoff * 100 + m_voff);
      chk(cap_hpos == hb && cap_vpos == vb, "R4", {"capture ", tag}, cap_hpos * 100 + cap_vpos, hb * 100 + vb);
      chk(cap_valid, "R5", {"valid strobe ", tag}, int'(cap_valid), 1);
      chk(slave_mode, "R6", {"slave entered ", tag}, int'(slave_mode), 1);
      @(negedge clk);
      chk(!cap_valid, "R5", {"strobe one cycle ", tag}, int'(cap_valid), 0);
      chk(h_pos == (m_hoff + 1) % LINE, "R3", {"count after reload ", tag}, h_pos, (m_hoff + 1) % LINE);
    end else begin
      chk(h_pos == (hb + 1) % LINE && !cap_valid, "R1", {"opposite edge ignored ", tag},
          h_pos * 10 + int'(cap_valid), ((hb + 1) % LINE) * 10);
      chk(slave_mode == mb && cap_hpos == cb, "R1", {"mode/capture untouched ", tag}, int'(slave_mode), mb);
    end
  endtask

  // R10
  task automatic t_por();
    int hb, cb;
    @(negedge clk); hb = h_pos; cb = cap_hpos;
    por_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(h_pos == (hb + 5) % LINE, "R10", "counter runs through por", h_pos, (hb + 5) % LINE);
    chk(slave_mode && cap_hpos == cb, "R10", "mode/capture kept", int'(slave_mode), 1);
    chk(!cap_valid, "R10", "strobe held low", int'(cap_valid), 0);
    por_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_free_run();
    t_windows(10, 20, 2, 4, "plain");
    t_windows(60, 5, 14, 1, "wrapping");
    wr(1, 37); wr(2, 9);
    wr(0, 0);
    t_edge(1'b1, 1'b0, "rise while falling selected");
    wr(0, 1);
    t_edge(1'b0, 1'b0, "fall while rising selected");
    t_edge(1'b1, 1'b1, "rise selected");
    wr(0, 0); wr(1, LINE - 1); wr(2, FRAME - 1);
    t_edge(1'b0, 1'b1, "fall selected at last position");
    t_por();
    t_windows(60, 5, 14, 1, "after por");
    t_edge(1'b1, 1'b0, "rise after por");
    t_edge(1'b0, 1'b1, "offsets kept after por");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(10 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule